// File: doc/BRIEF.md
# Oversampled Audio Decimator, Ratio 128

This block turns a narrow oversampled audio stream into PCM words for one channel. Each input code is a few bits wide and two's complement, and it arrives with a valid qualifier. A valid sample is taken at any clock where the qualifier is high, so the input rate can be any fraction of the clock rate. After every 128 accepted samples the block emits one 20-bit PCM word with a one-cycle strobe.

The filtering is done in two steps. A third-order comb-integrator (sinc cubed) stage brings the rate down by 16. Three half-band FIR stages follow, and each of them halves the rate again. Each half-band stage uses the 7-tap kernel [-1, 0, 9, 16, 9, 0, -1]/32. Because its odd-offset taps are zero, it evaluates only on every second input. Every internal word is wide enough to keep its result exact. Rounding and clipping to 20 bits happen only once, at the output register.

A typical use is behind a sigma-delta modulator with a 4-bit output. There, full-scale input code -8 maps to the most negative PCM word.

Top module: `audio_decim128`

## Requirements
- R1: While reset is asserted, and after it until the first output word, `out_valid` is 0 and `out_data` is 0.
- R2: `out_valid` pulses for one cycle per 128 accepted inputs. The pulse comes exactly 5 clock cycles after the cycle in which the 128th, 256th, ... input since reset is accepted, whatever the gaps between inputs.
- R3: The first stage gives, for accepted input x[n] (n counted from 0 after reset), c[k] = sum over j of w[j]·x[16k+15-j]. Here w[j] is the number of ways to write j as a+b+c with 0 ≤ a,b,c ≤ 15, and x before reset counts as 0. The result is exact even though the integrators wrap.
- R4: Each half-band stage maps its input sequence a[] to y[k] = -a[2k+1] + 9a[2k-1] + 16a[2k-2] + 9a[2k-3] - a[2k-5], with no scaling. Negative indices count as 0.
- R5: The output word is the third half-band result r, computed as floor((r + 1024) / 2048), then clipped to the range [-524288, 524287].
- R6: A constant input c gives, once settled, an output of exactly c·65536.
- R7: `in_data` is ignored in cycles where `in_valid` is 0.
- R8: A reset during operation restarts the block. Later outputs match those of a block fresh out of reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| in_valid | input | 1 | Input sample qualifier |
| in_data | input | W_IN (4) | Oversampled sample, two's complement |
| out_valid | output | 1 | One-cycle strobe for a new PCM word |
| out_data | output | W_OUT (20) | PCM word, two's complement, held between strobes |

## Verification
Each output word depends on the 128th input of its block. That input passes through five registers: the comb output, three half-band output registers and the rounding register. The word therefore shows up 5 cycles after that input is accepted. The bench records the cycle of every accepted input. When it sees a strobe, it requires that strobe to come exactly 5 cycles after the matching input. It compares each word, in order, with a list of expected values that it computes beforehand from the formulas above. All outputs are sampled on the falling clock edge, so the registered values have settled when they are read.

// File: rtl/decim_pkg.sv
package decim_pkg;
  localparam int CIC_ORDER    = 3;  // sinc^3 front end
  localparam int HB_TAPS      = 7;  // half-band kernel length
  localparam int HB_GROWTH    = 6;  // bits added per half-band (sum |h| = 36)
  localparam int HB_NORM_LOG2 = 5;  // kernel DC gain 32 = 2^5
endpackage

// File: rtl/cic_sinc3_dec.sv
module cic_sinc3_dec #(
  parameter int W_IN     = 4,
  parameter int DEC_LOG2 = 4,
  parameter int ORDER    = decim_pkg::CIC_ORDER,
  localparam int W_C     = W_IN + ORDER * DEC_LOG2
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  x_valid,
  input  logic signed [W_IN-1:0] x_data,
  output logic                  y_valid,
  output logic signed [W_C-1:0] y_data
);
  logic [DEC_LOG2-1:0] phase_q;
  logic                fire;
  logic signed [W_C-1:0] x_ext;
  logic signed [W_C-1:0] acc_q [ORDER];
  logic signed [W_C-1:0] acc_d [ORDER];
  logic signed [W_C-1:0] src   [ORDER];
  logic signed [W_C-1:0] dly_q [ORDER];
  logic signed [W_C-1:0] diff  [ORDER];

  assign x_ext = W_C'(x_data);
  assign fire  = x_valid && (&phase_q);

  // integrators run at input rate and wrap modulo 2^W_C
  for (genvar k = 0; k < ORDER; k++) begin : g_int
    if (k == 0) begin : g_head
      assign acc_d[k] = acc_q[k] + x_ext;
    end else begin : g_tail
      assign acc_d[k] = acc_q[k] + acc_d[k-1];
    end
  end

  // combs run at the decimated rate, differential delay of one
  for (genvar k = 0; k < ORDER; k++) begin : g_cmb
    if (k == 0) begin : g_head
      assign src[k] = acc_d[ORDER-1];
    end else begin : g_tail
      assign src[k] = diff[k-1];
    end
    assign diff[k] = src[k] - dly_q[k];
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      phase_q <= '0;
      y_valid <= 1'b0;
      y_data  <= '0;
      for (int i = 0; i < ORDER; i++) begin
        acc_q[i] <= '0;
        dly_q[i] <= '0;
      end
    end else begin
      y_valid <= fire;
      if (x_valid) begin
        phase_q <= phase_q + 1'b1;
        for (int i = 0; i < ORDER; i++) acc_q[i] <= acc_d[i];
      end
      if (fire) begin
        for (int i = 0; i < ORDER; i++) dly_q[i] <= src[i];
        y_data <= diff[ORDER-1];
      end
    end
  end
endmodule

// File: rtl/halfband_dec2.sv
module halfband_dec2 import decim_pkg::*; #(
  parameter int W_IN   = 16,
  localparam int W_OUT = W_IN + HB_GROWTH
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic                   x_valid,
  input  logic signed [W_IN-1:0]  x_data,
  output logic                   y_valid,
  output logic signed [W_OUT-1:0] y_data
);
  localparam int DEPTH = HB_TAPS - 1;

  logic signed [W_IN-1:0] dly_q [DEPTH];
  logic                   phase_q;
  logic                   take;

  // evaluate only on odd input positions: half the work of a plain FIR
  assign take = x_valid && phase_q;

  // kernel [-1 0 9 16 9 0 -1], zero taps skipped, coefficients as shifts
  function automatic logic signed [W_OUT-1:0] hb_sum(
    input logic signed [W_IN-1:0] t0,
    input logic signed [W_IN-1:0] t2,
    input logic signed [W_IN-1:0] t3,
    input logic signed [W_IN-1:0] t4,
    input logic signed [W_IN-1:0] t6
  );
    logic signed [W_OUT-1:0] outer, inner, mid;
    outer = W_OUT'(t0) + W_OUT'(t6);
    inner = W_OUT'(t2) + W_OUT'(t4);
    mid   = W_OUT'(t3);
    return (inner <<< 3) + inner + (mid <<< 4) - outer;
  endfunction

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      phase_q <= 1'b0;
      y_valid <= 1'b0;
      y_data  <= '0;
      for (int i = 0; i < DEPTH; i++) dly_q[i] <= '0;
    end else begin
      y_valid <= take;
      if (x_valid) begin
        phase_q  <= ~phase_q;
        dly_q[0] <= x_data;
        for (int i = 1; i < DEPTH; i++) dly_q[i] <= dly_q[i-1];
      end
      if (take) y_data <= hb_sum(x_data, dly_q[1], dly_q[2], dly_q[3], dly_q[5]);
    end
  end
endmodule

// File: rtl/audio_decim128.sv
module audio_decim128 import decim_pkg::*; #(
  parameter int W_IN     = 4,
  parameter int W_OUT    = 20,
  parameter int CIC_LOG2 = 4,
  parameter int NUM_HB   = 3
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    in_valid,
  input  logic signed [W_IN-1:0]  in_data,
  output logic                    out_valid,
  output logic signed [W_OUT-1:0] out_data
);
  localparam int W_CIC = W_IN + CIC_ORDER * CIC_LOG2;
  localparam int W_ACC = W_CIC + NUM_HB * HB_GROWTH;
  localparam int SHIFT = CIC_ORDER * CIC_LOG2 + NUM_HB * HB_NORM_LOG2 + W_IN - W_OUT;
  localparam logic signed [W_ACC:0] MAXV = (W_ACC+1)'((64'sd1 <<< (W_OUT - 1)) - 64'sd1);
  localparam logic signed [W_ACC:0] MINV = -MAXV - 1;

  // named internal events for the checker
  logic                    cic_v;
  logic signed [W_CIC-1:0] cic_d;
  logic [NUM_HB-1:0]       stage_v;
  logic signed [W_ACC-1:0] final_d;

  cic_sinc3_dec #(.W_IN(W_IN), .DEC_LOG2(CIC_LOG2), .ORDER(CIC_ORDER)) u_cic (
    .clk(clk), .rst_n(rst_n), .x_valid(in_valid), .x_data(in_data),
    .y_valid(cic_v), .y_data(cic_d)
  );

  for (genvar i = 0; i < NUM_HB; i++) begin : g_hb
    localparam int WI = W_CIC + i * HB_GROWTH;
    logic                           in_v;
    logic signed [WI-1:0]           in_d;
    logic                           y_v;
    logic signed [WI+HB_GROWTH-1:0] y_d;
    if (i == 0) begin : g_src_cic
      assign in_v = cic_v;
      assign in_d = cic_d;
    end else begin : g_src_hb
      assign in_v = g_hb[i-1].y_v;
      assign in_d = g_hb[i-1].y_d;
    end
    halfband_dec2 #(.W_IN(WI)) u_hb (
      .clk(clk), .rst_n(rst_n), .x_valid(in_v), .x_data(in_d),
      .y_valid(y_v), .y_data(y_d)
    );
    assign stage_v[i] = y_v;
  end

  assign final_d = g_hb[NUM_HB-1].y_d;

  // round half up by SHIFT bits, then clip to W_OUT
  function automatic logic signed [W_OUT-1:0] round_sat(input logic signed [W_ACC-1:0] v);
    logic signed [W_ACC:0] t;
    logic signed [W_ACC:0] q;
    t = $signed({v[W_ACC-1], v}) + $signed({{(W_ACC+1-SHIFT){1'b0}}, 1'b1, {(SHIFT-1){1'b0}}});
    q = t >>> SHIFT;
    if (q > MAXV)      return MAXV[W_OUT-1:0];
    else if (q < MINV) return MINV[W_OUT-1:0];
    else               return q[W_OUT-1:0];
  endfunction

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      out_valid <= 1'b0;
      out_data  <= '0;
    end else begin
      out_valid <= stage_v[NUM_HB-1];
      if (stage_v[NUM_HB-1]) out_data <= round_sat(final_d);
    end
  end
endmodule

// File: rtl/decim_checker.sv
module decim_checker #(
  parameter int CIC_LOG2 = 4,
  parameter int NUM_HB   = 3
) (
  input logic              clk,
  input logic              rst_n,
  input logic              in_valid,
  input logic              cic_v,
  input logic [NUM_HB-1:0] stage_v,
  input logic              out_valid
);
  localparam int RATIO_LOG2 = CIC_LOG2 + NUM_HB;
  localparam int LAT        = NUM_HB + 2;

  logic [RATIO_LOG2-1:0] cnt;
  logic                  block_end;
  logic                  cic_due;
  logic [LAT-1:0]        end_pipe;

  assign block_end = in_valid && (&cnt);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cnt      <= '0;
      cic_due  <= 1'b0;
      end_pipe <= '0;
    end else begin
      if (in_valid) cnt <= cnt + 1'b1;
      cic_due  <= in_valid && (&cnt[CIC_LOG2-1:0]);
      end_pipe <= {end_pipe[LAT-2:0], block_end};
    end
  end

  // R2: strobe exactly LAT cycles after each 128th accepted input
  assert_out_timing_R2: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid == end_pipe[LAT-1]);

  // R2: strobe is a single cycle wide
  assert_out_single_R2: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |=> !out_valid);

  // R2: pipeline events never coincide
  assert_events_apart_R2: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({cic_v, stage_v, out_valid}));

  // R3: first stage fires one cycle after every 16th accepted input only
  assert_cic_rate_R3: assert property (@(posedge clk) disable iff (!rst_n)
    cic_v == cic_due);

  // R4: each half-band result follows an event of the stage before it
  for (genvar i = 0; i < NUM_HB; i++) begin : g_chain
    if (i == 0) begin : g_first
      assert_hb_chain_R4: assert property (@(posedge clk) disable iff (!rst_n)
        stage_v[i] |-> $past(cic_v));
    end else begin : g_rest
      assert_hb_chain_R4: assert property (@(posedge clk) disable iff (!rst_n)
        stage_v[i] |-> $past(stage_v[i-1]));
    end
  end
endmodule

bind audio_decim128 decim_checker #(.CIC_LOG2(CIC_LOG2), .NUM_HB(NUM_HB)) u_chk (
  .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .cic_v(cic_v),
  .stage_v(stage_v), .out_valid(out_valid)
);

// File: tb/sim_audio_decim128.sv
`timescale 1ns/1ps
module sim_audio_decim128;
  logic              clk = 1'b0;
  logic              rst_n = 1'b0;
  logic              in_valid = 1'b0;
  logic signed [3:0]  in_data = '0;
  logic              out_valid;
  logic signed [19:0] out_data;

  int errors = 0;
  int checks = 0;

  int     xs     [0:4095];
  int     in_cyc [0:4095];
  longint stg    [0:3][0:1023];
  longint expv   [0:63];
  longint w3     [0:45];
  int     clamp_seen;

  always #2 clk = ~clk;

  audio_decim128 u0 (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_data(in_data),
    .out_valid(out_valid), .out_data(out_data)
  );

  task automatic check(input bit ok, input string req, input longint act, input longint exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  function automatic longint at(input int s, input int i);
    return (i < 0) ? 64'sd0 : stg[s][i];
  endfunction

  function automatic longint rnd_clip(input longint v);
    longint q;
    q = (v + 64'sd1024) >>> 11;
    if (q > 64'sd524287) q = 64'sd524287;
    if (q < -64'sd524288) q = -64'sd524288;
    return q;
  endfunction

  // expected outputs from the requirement formulas (R3, R4, R5)
  task automatic compute(input int n_out);
    for (int k = 0; k < n_out * 8; k++) begin
      longint s = 0;
      for (int j = 0; j < 46; j++)
        if (16 * k + 15 - j >= 0) s += w3[j] * xs[16 * k + 15 - j];
      stg[0][k] = s;
    end
    for (int s = 1; s <= 3; s++)
      for (int k = 0; k < n_out * (8 >> s); k++)
        stg[s][k] = -at(s-1, 2*k+1) + 9 * at(s-1, 2*k-1) + 16 * at(s-1, 2*k-2)
                    + 9 * at(s-1, 2*k-3) - at(s-1, 2*k-5);
    for (int k = 0; k < n_out; k++) expv[k] = rnd_clip(stg[3][k]);
  endtask

  task automatic run_phase(input int n_out, input int mode, input string tag);
    int n_in = n_out * 128;
    int issued = 0;
    int got = 0;
    int cyc = 0;
    rst_n = 1'b0;
    in_valid = 1'b0;
    repeat (3) @(negedge clk);
    check(out_valid == 1'b0 && out_data == 0, "R1 reset state", longint'(out_data), 0);
    rst_n = 1'b1;
    @(negedge clk);
    check(out_valid == 1'b0 && out_data == 0, "R1 after reset", longint'(out_data), 0);
    for (int i = 0; i < n_in; i++) begin
      case (mode)
        0: xs[i] = int'($urandom_range(15)) - 8;
        1: xs[i] = 5;
        default: xs[i] = (i < n_in / 2) ? 7 : -8;
      endcase
    end
    compute(n_out);
    clamp_seen = 0;
    while (got < n_out && cyc < n_in * 3 + 500) begin
      @(negedge clk);
      cyc++;
      if (out_valid) begin
        check(longint'(out_data) == expv[got], {tag, " value"}, longint'(out_data), expv[got]);
        check(cyc - in_cyc[128 * got + 127] == 5, "R2 latency",
              cyc - in_cyc[128 * got + 127], 5);
        if (mode == 1 && got >= n_out - 4)
          check(longint'(out_data) == 327680, "R6 dc gain", longint'(out_data), 327680);
        if (out_data == -20'sd524288) clamp_seen++;
        got++;
      end
      // R7: gaps carry random data that must be ignored
      if (issued < n_in && $urandom_range(3) != 0) begin
        in_valid = 1'b1;
        in_data = 4'(xs[issued]);
        in_cyc[issued] = cyc;
        issued++;
      end else begin
        in_valid = 1'b0;
        in_data = 4'($urandom_range(15));
      end
    end
    check(got == n_out, "R2 output count", got, n_out);
    in_valid = 1'b0;
    for (int i = 0; i < 140; i++) begin
      @(negedge clk);
      if (out_valid) check(1'b0, "R2 extra strobe", 1, 0);
    end
    if (mode == 2) check(clamp_seen > 0, "R5 negative clip reached", clamp_seen, 1);
  endtask

  initial begin
    void'($urandom(32'd2718));
    for (int j = 0; j < 46; j++) w3[j] = 0;
    for (int a = 0; a < 16; a++)
      for (int b = 0; b < 16; b++)
        for (int c = 0; c < 16; c++) w3[a + b + c]++;
    run_phase(24, 0, "R3 R4 R5 R7");
    run_phase(16, 1, "R3 R4 R6 R7");
    run_phase(16, 2, "R4 R5 R7");
    // R8: disturb the state, then reset mid-stream
    rst_n = 1'b1;
    for (int i = 0; i < 300; i++) begin
      @(negedge clk);
      in_valid = 1'b1;
      in_data = 4'($urandom_range(15));
    end
    run_phase(8, 0, "R8 restart");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    errors++;
    checks++;
    $display("FAIL watchdog R2 actual=%0d expected=%0d", 0, 1);
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule